// File: doc/BRIEF.md
# Bit-serial bus-cycle EEPROM controller

This block holds the control logic of a small nonvolatile byte store that a host reaches through plain bus read and write cycles on one data line. It has chip-enable, output-enable and write-enable strobes, a write-protect input and a single data bit, which is split into an input, an output and an output enable. There are no opcodes. The block works out each operation from the order of host read and write cycles and from the one bit that each write cycle carries. The operations are: reset, address load, sequential read, page load, start of a nonvolatile write, and busy reporting.

The strobes are resampled on the system clock. A bus cycle counts once its strobes return high. Inside are:
- a serial address register with an auto-incrementing byte address;
- a one-page buffer with a mask of the bytes that were loaded;
- a write-enable latch;
- a busy timer that counts a parameter number of clocks and then copies the loaded bytes of the page buffer into an internal register array.

Top module: `bsee_ctrl`

## Requirements
- R1: A write cycle is chip-enable low, write-enable low and output-enable high. A read cycle is chip-enable low, output-enable low and write-enable high. A write cycle takes the data bit it last sampled at the moment it ends. The data output is enabled only while a read cycle is in progress, and never during a write cycle.
- R2: A read, then a write of 0, then a read resets the sequencer. It aborts a sequential read or a page load and sets the write-enable latch. From the reset until a full address has been loaded, every read returns 1.
- R3: After the reset, the address is taken from 16 write cycles, most significant bit first, with no read between them. Only the low ADDR_BITS bits select a byte.
- R4: Once the address is loaded, each group of 8 read cycles returns one byte, most significant bit first. The address then increments and wraps from the top byte to byte 0.
- R5: A write of 1 after the last bit of a byte ends the sequential read. Later reads return 1.
- R6: Write cycles that follow a loaded address are shifted in 8 bits per byte, most significant bit first. The in-page byte index starts at the low address bits and wraps within the PAGE_BYTES page. Committing the page updates only the bytes that were loaded.
- R7: After a page load of whole bytes, a read, then a write of 1, then a read starts the nonvolatile write, provided the write-enable latch is set. A page load that ends on a partial byte does not start it.
- R8: While the nonvolatile write is busy, every read returns 0 and every bus cycle is ignored. A reset sequence issued then is ignored too. After completion, reads return 1.
- R9: The write-enable latch is clear after reset, clears when a nonvolatile write starts, clears after an invalid write, and stays clear while write-protect is low. Write-protect going low during a busy period does not abort that write.
- R10: Each of these sends the sequencer to idle, where reads return 1: a read followed by two writes; a read followed by a write of 1 while the address or data is loading; a write of 1 partway through a byte read.
- R11: The busy period lasts exactly BUSY_CYCLES clocks and ends with the page commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| wp_n | input | 1 | Write protect, low blocks nonvolatile writes |
| dq_in | input | 1 | Serial data bit from the host |
| dq_out | output | 1 | Serial data or status bit to the host |
| dq_oe | output | 1 | High while dq_out should drive the data line |

## Verification
The bench keeps the defaults of 256 bytes with 32-byte pages and two synchroniser stages, and shortens BUSY_CYCLES to 50. With only 256 bytes, the wrap of the sequential read from the top byte to byte 0 takes a handful of host cycles. A full page load, its in-page wrap, and the partial update of an already written page also fit in a short run. The short busy period lets the bench read the busy status, issue a reset sequence and drop write-protect within one write, and then see the result committed soon after.

// File: rtl/bsee_pkg.sv
package bsee_pkg;
  localparam int SER_ADDR_W = 16;

  typedef enum logic [1:0] {
    EV_NONE,
    EV_RD,
    EV_WR0,
    EV_WR1
  } bus_ev_e;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_AFTER_RD,
    SQ_RST_W0,
    SQ_ADDR,
    SQ_ADDR_OK,
    SQ_RDATA,
    SQ_WDATA,
    SQ_PAGE_END,
    SQ_ARM
  } seq_st_e;
endpackage

// File: rtl/bsee_bus_events.sv
module bsee_bus_events
  import bsee_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ce_n,
  input  logic    oe_n,
  input  logic    we_n,
  input  logic    wp_n,
  input  logic    dq_in,
  output bus_ev_e ev,
  output logic    rd_act,
  output logic    wp_ok
);
  // bit order {ce, oe, we, wp, dq}
  localparam logic [4:0] IDLE_PINS = 5'b11101;

  logic [SYNC_STAGES-1:0][4:0] stage;
  logic [4:0] pins_s;
  logic wr_now, rd_now;
  logic wr_q, rd_q, bit_q;
  logic wr_n, rd_n, bit_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= {SYNC_STAGES{IDLE_PINS}};
    end else begin
      stage[0] <= {ce_n, oe_n, we_n, wp_n, dq_in};
      for (int i = 1; i < SYNC_STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign pins_s = stage[SYNC_STAGES-1];
  assign wr_now = !pins_s[4] &&  pins_s[3] && !pins_s[2];
  assign rd_now = !pins_s[4] && !pins_s[3] &&  pins_s[2];
  assign wp_ok  = pins_s[1];

  always_comb begin
    wr_n  = wr_now;
    rd_n  = rd_now;
    bit_n = bit_q;
    if (wr_now) bit_n = pins_s[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= 1'b0;
      rd_q  <= 1'b0;
      bit_q <= 1'b0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      bit_q <= bit_n;
    end
  end

  always_comb begin
    ev = EV_NONE;
    if (wr_q && !wr_now)      ev = bit_q ? EV_WR1 : EV_WR0;
    else if (rd_q && !rd_now) ev = EV_RD;
  end

  assign rd_act = rd_q;
endmodule

// File: rtl/bsee_seq.sv
module bsee_seq
  import bsee_pkg::*;
#(
  parameter int ADDR_BITS  = 8,
  parameter int PAGE_BYTES = 32,
  localparam int PW        = $clog2(PAGE_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  bus_ev_e              ev,
  input  logic                 busy,
  input  logic                 wp_ok,
  input  logic [7:0]           rd_byte,
  output logic [ADDR_BITS-1:0] addr,
  output logic                 pb_we,
  output logic [PW-1:0]        pb_idx,
  output logic [7:0]           pb_byte,
  output logic                 pb_clr,
  output logic                 start,
  output logic                 wel,
  output logic                 dq_val
);
  seq_st_e st, st_n;
  logic [3:0] cnt, cnt_n;
  logic [SER_ADDR_W-1:0] sh, sh_n, sh_in;
  logic [ADDR_BITS-1:0] addr_n;
  logic [PW-1:0] idx, idx_n;
  logic any_q, any_n;
  logic wel_n;
  logic wbit;
  logic do_reset;

  assign wbit  = (ev == EV_WR1);
  assign sh_in = {sh[SER_ADDR_W-2:0], wbit};

  always_comb begin
    st_n     = st;
    cnt_n    = cnt;
    sh_n     = sh;
    addr_n   = addr;
    idx_n    = idx;
    any_n    = any_q;
    wel_n    = wel;
    pb_we    = 1'b0;
    pb_clr   = 1'b0;
    start    = 1'b0;
    do_reset = 1'b0;
    if (!busy && ev != EV_NONE) begin
      unique case (st)
        SQ_IDLE: begin
          if (ev == EV_RD) st_n = SQ_AFTER_RD;
          else wel_n = 1'b0;
        end
        SQ_AFTER_RD: begin
          if (ev == EV_WR0) do_reset = 1'b1;
          else if (ev == EV_WR1) begin
            st_n  = SQ_IDLE;
            wel_n = 1'b0;
          end
        end
        SQ_RST_W0: begin
          if (ev == EV_RD) begin
            st_n  = SQ_ADDR;
            cnt_n = 4'd0;
          end else begin
            st_n  = SQ_IDLE;
            wel_n = 1'b0;
          end
        end
        SQ_ADDR: begin
          if (ev == EV_RD) st_n = SQ_AFTER_RD;
          else begin
            sh_n = sh_in;
            if (cnt == 4'd15) begin
              addr_n = sh_in[ADDR_BITS-1:0];
              st_n   = SQ_ADDR_OK;
              cnt_n  = 4'd0;
            end else begin
              cnt_n = cnt + 4'd1;
            end
          end
        end
        SQ_ADDR_OK, SQ_RDATA: begin
          if (ev == EV_RD) begin
            st_n = SQ_RDATA;
            if (cnt == 4'd7) begin
              addr_n = addr + 1'b1;
              cnt_n  = 4'd0;
            end else begin
              cnt_n = cnt + 4'd1;
            end
          end else if (st == SQ_ADDR_OK) begin
            st_n  = SQ_WDATA;
            sh_n  = sh_in;
            cnt_n = 4'd1;
            idx_n = addr[PW-1:0];
            any_n = 1'b0;
          end else if (ev == EV_WR0) begin
            do_reset = 1'b1;
          end else begin
            st_n  = SQ_IDLE;
            wel_n = 1'b0;
          end
        end
        SQ_WDATA: begin
          if (ev == EV_RD) begin
            if (cnt == 4'd0 && any_q) st_n = SQ_PAGE_END;
            else begin
              st_n  = SQ_AFTER_RD;
              wel_n = 1'b0;
            end
          end else begin
            sh_n = sh_in;
            if (cnt == 4'd7) begin
              pb_we = 1'b1;
              idx_n = idx + 1'b1;
              any_n = 1'b1;
              cnt_n = 4'd0;
            end else begin
              cnt_n = cnt + 4'd1;
            end
          end
        end
        SQ_PAGE_END: begin
          if (ev == EV_WR1) st_n = SQ_ARM;
          else if (ev == EV_WR0) do_reset = 1'b1;
          else begin
            st_n  = SQ_AFTER_RD;
            wel_n = 1'b0;
          end
        end
        SQ_ARM: begin
          if (ev == EV_RD) start = wel;
          st_n  = SQ_IDLE;
          wel_n = 1'b0;
        end
        default: st_n = SQ_IDLE;
      endcase
    end
    if (do_reset) begin
      st_n   = SQ_RST_W0;
      cnt_n  = 4'd0;
      pb_clr = 1'b1;
      wel_n  = wp_ok;
    end
    if (!wp_ok) wel_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= SQ_IDLE;
      cnt   <= 4'd0;
      sh    <= '0;
      addr  <= '0;
      idx   <= '0;
      any_q <= 1'b0;
      wel   <= 1'b0;
    end else begin
      st    <= st_n;
      cnt   <= cnt_n;
      sh    <= sh_n;
      addr  <= addr_n;
      idx   <= idx_n;
      any_q <= any_n;
      wel   <= wel_n;
    end
  end

  assign pb_idx  = idx;
  assign pb_byte = sh_in[7:0];

  always_comb begin
    if (busy) dq_val = 1'b0;
    else if (st == SQ_ADDR_OK || st == SQ_RDATA) dq_val = rd_byte[3'd7 - cnt[2:0]];
    else dq_val = 1'b1;
  end
endmodule

// File: rtl/bsee_nvm.sv
module bsee_nvm #(
  parameter int ADDR_BITS   = 8,
  parameter int PAGE_BYTES  = 32,
  parameter int BUSY_CYCLES = 64,
  localparam int PW         = $clog2(PAGE_BYTES),
  localparam int DEPTH      = 1 << ADDR_BITS,
  localparam int TW         = $clog2(BUSY_CYCLES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pb_we,
  input  logic [PW-1:0]        pb_idx,
  input  logic [7:0]           pb_byte,
  input  logic                 pb_clr,
  input  logic                 start,
  input  logic [ADDR_BITS-1:0] addr,
  output logic [7:0]           rd_byte,
  output logic                 busy,
  output logic                 commit
);
  localparam logic [TW-1:0] LAST = TW'(BUSY_CYCLES - 1);

  logic [7:0] mem  [DEPTH];
  logic [7:0] pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask, mask_n;
  logic [ADDR_BITS-PW-1:0] pg_q, pg_n;
  logic [TW-1:0] tmr, tmr_n;
  logic busy_n;

  always_ff @(posedge clk) begin
    if (pb_we) pbuf[pb_idx] <= pb_byte;
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_mask
    always_comb begin
      if (pb_clr) mask_n[g] = 1'b0;
      else if (pb_we && pb_idx == PW'(g)) mask_n[g] = 1'b1;
      else mask_n[g] = mask[g];
    end
  end

  assign commit = busy && (tmr == LAST);

  always_comb begin
    busy_n = busy;
    tmr_n  = tmr;
    pg_n   = pg_q;
    if (start && !busy) begin
      busy_n = 1'b1;
      tmr_n  = '0;
      pg_n   = addr[ADDR_BITS-1:PW];
    end else if (commit) begin
      busy_n = 1'b0;
      tmr_n  = '0;
    end else if (busy) begin
      tmr_n = tmr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      pg_q <= '0;
      tmr  <= '0;
      busy <= 1'b0;
    end else begin
      mask <= mask_n;
      pg_q <= pg_n;
      tmr  <= tmr_n;
      busy <= busy_n;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < PAGE_BYTES; i++) begin
      if (commit && mask[i]) mem[{pg_q, i[PW-1:0]}] <= pbuf[i];
    end
  end

  assign rd_byte = mem[addr];
endmodule

// File: rtl/bsee_ctrl.sv
module bsee_ctrl
  import bsee_pkg::*;
#(
  parameter int ADDR_BITS   = 8,
  parameter int PAGE_BYTES  = 32,
  parameter int BUSY_CYCLES = 64,
  parameter int SYNC_STAGES = 2,
  localparam int PW         = $clog2(PAGE_BYTES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  input  logic wp_n,
  input  logic dq_in,
  output logic dq_out,
  output logic dq_oe
);
  logic [1:0] rst_pipe;
  logic rst_core_n;
  bus_ev_e ev;
  logic rd_act, wp_ok;
  logic [ADDR_BITS-1:0] addr;
  logic pb_we, pb_clr, start, wel, dq_val, busy, commit;
  logic [PW-1:0] pb_idx;
  logic [7:0] pb_byte, rd_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  bsee_bus_events #(.SYNC_STAGES(SYNC_STAGES)) u_events (
    .clk(clk), .rst_n(rst_core_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .wp_n(wp_n), .dq_in(dq_in), .ev(ev), .rd_act(rd_act), .wp_ok(wp_ok)
  );

  bsee_seq #(.ADDR_BITS(ADDR_BITS), .PAGE_BYTES(PAGE_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_core_n), .ev(ev), .busy(busy), .wp_ok(wp_ok),
    .rd_byte(rd_byte), .addr(addr), .pb_we(pb_we), .pb_idx(pb_idx),
    .pb_byte(pb_byte), .pb_clr(pb_clr), .start(start), .wel(wel), .dq_val(dq_val)
  );

  bsee_nvm #(.ADDR_BITS(ADDR_BITS), .PAGE_BYTES(PAGE_BYTES), .BUSY_CYCLES(BUSY_CYCLES)) u_nvm (
    .clk(clk), .rst_n(rst_core_n), .pb_we(pb_we), .pb_idx(pb_idx), .pb_byte(pb_byte),
    .pb_clr(pb_clr), .start(start), .addr(addr), .rd_byte(rd_byte),
    .busy(busy), .commit(commit)
  );

  assign dq_oe  = rd_act;
  assign dq_out = dq_val;
endmodule

// File: rtl/bsee_ctrl_chk.sv
module bsee_ctrl_chk #(
  parameter int BUSY_CYCLES = 64
) (
  input logic clk,
  input logic rst_n,
  input logic dq_oe,
  input logic dq_out,
  input logic busy,
  input logic wel,
  input logic wp_ok,
  input logic commit
);
  int busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else busy_run <= 0;
  end

  // R8: status reads low while busy
  a_r8_busy_reads_low: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dq_oe) |-> !dq_out);

  // R9: latch held clear while protected
  a_r9_wp_clears_wel: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_ok |=> !wel);

  // R9: latch set only when unprotected
  a_r9_wel_set_unprot: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(wp_ok));

  // R7: busy begins only with the latch set
  a_r7_start_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel));

  // R11: busy window bounded
  a_r11_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_run < BUSY_CYCLES));

  // R11: busy ends through the commit
  a_r11_end_commits: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(commit));

  // R11: commit happens after the full window
  a_r11_commit_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (busy_run == BUSY_CYCLES - 1));
endmodule

bind bsee_ctrl bsee_ctrl_chk #(.BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .dq_oe(dq_oe), .dq_out(dq_out), .busy(busy),
  .wel(wel), .wp_ok(wp_ok), .commit(commit)
);

// File: tb/tb_bsee_ctrl.sv
`timescale 1ns/1ps
module tb_bsee_ctrl;
  localparam int BUSY = 50;
  localparam int HOLD = 6;

  logic clk, rst_n, ce_n, oe_n, we_n, wp_n, dq_in;
  logic dq_out, dq_oe;
  int n_chk, n_fail;
  bit done;
  logic [7:0] exp_mem [256];
  logic [7:0] wbuf [32];

  bsee_ctrl #(.ADDR_BITS(8), .PAGE_BYTES(32), .BUSY_CYCLES(BUSY), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .wp_n(wp_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_bit(input logic b);
    @(negedge clk);
    dq_in = b; ce_n = 1'b0; we_n = 1'b0;
    repeat (HOLD) @(posedge clk);
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    repeat (HOLD) @(posedge clk);
  endtask

  task automatic rd_bit(output logic b);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0;
    repeat (HOLD) @(posedge clk);
    @(negedge clk);
    b = dq_out;
    ce_n = 1'b1; oe_n = 1'b1;
    repeat (HOLD) @(posedge clk);
  endtask

  task automatic rst_seq(output logic last);
    logic d;
    rd_bit(d); wr_bit(1'b0); rd_bit(last);
  endtask

  task automatic send_addr(input logic [15:0] a);
    for (int i = 15; i >= 0; i--) wr_bit(a[i]);
  endtask

  task automatic rd_byte(output logic [7:0] v);
    for (int i = 7; i >= 0; i--) rd_bit(v[i]);
  endtask

  task automatic wait_done();
    repeat (BUSY + 40) @(posedge clk);
  endtask

  task automatic start_seq(output logic last);
    logic d;
    rd_bit(d); wr_bit(1'b1); rd_bit(last);
  endtask

  // reset, address, n bytes from wbuf, start sequence; model update if expected
  task automatic load_page(input logic [7:0] a, input int n, input bit commit_exp, output logic st_bit);
    logic d;
    rst_seq(d);
    send_addr({8'h00, a});
    for (int k = 0; k < n; k++)
      for (int i = 7; i >= 0; i--) wr_bit(wbuf[k][i]);
    start_seq(st_bit);
    if (commit_exp)
      for (int k = 0; k < n; k++) exp_mem[{a[7:5], 5'(a[4:0] + k)}] = wbuf[k];
  endtask

  task automatic verify(input logic [7:0] a, input int n, input string req);
    logic d;
    logic [7:0] v;
    rst_seq(d);
    send_addr({8'h00, a});
    for (int k = 0; k < n; k++) begin
      rd_byte(v);
      check(v === exp_mem[8'(a + k)], req, v, exp_mem[8'(a + k)]);
    end
    wr_bit(1'b1);
  endtask

  task automatic t_reset_state();
    logic b;
    @(negedge clk);
    check(dq_oe === 1'b0, "R1 oe idle", dq_oe, 0);
    ce_n = 1'b0; we_n = 1'b0; dq_in = 1'b1;
    repeat (HOLD) @(posedge clk);
    @(negedge clk);
    check(dq_oe === 1'b0, "R1 oe during write", dq_oe, 0);
    ce_n = 1'b1; we_n = 1'b1;
    repeat (HOLD) @(posedge clk);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0;
    repeat (HOLD) @(posedge clk);
    @(negedge clk);
    check(dq_oe === 1'b1, "R1 oe during read", dq_oe, 1);
    check(dq_out === 1'b1, "R8 idle status", dq_out, 1);
    ce_n = 1'b1; oe_n = 1'b1;
    repeat (HOLD) @(posedge clk);
    wr_bit(1'b1);
  endtask

  task automatic t_full_page();
    logic b;
    for (int k = 0; k < 32; k++) wbuf[k] = 8'(k * 7 + 3);
    load_page(8'h20, 32, 1'b1, b);
    rd_bit(b);
    check(b === 1'b0, "R8 busy reads 0", b, 0);
    wait_done();
    rd_bit(b);
    check(b === 1'b1, "R8 done reads 1", b, 1);
    verify(8'h20, 32, "R4 R6 full page");
  endtask

  task automatic t_partial_update();
    logic b;
    wbuf[0] = 8'hC3; wbuf[1] = 8'h96;
    load_page(8'h21, 2, 1'b1, b);
    wait_done();
    verify(8'h20, 4, "R6 only loaded bytes");
  endtask

  task automatic t_page_wrap();
    logic b;
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    load_page(8'h3E, 3, 1'b1, b);
    wait_done();
    verify(8'h3E, 2, "R6 wrap tail");
    verify(8'h20, 1, "R6 wrap head");
  endtask

  task automatic t_rollover();
    logic b;
    wbuf[0] = 8'hE7; load_page(8'hFF, 1, 1'b1, b); wait_done();
    wbuf[0] = 8'h18; load_page(8'h00, 1, 1'b1, b); wait_done();
    verify(8'hFF, 2, "R3 R4 rollover");
  endtask

  task automatic t_end_read();
    logic b;
    logic [7:0] v;
    rst_seq(b);
    send_addr(16'h003E);
    rd_byte(v);
    check(v === 8'h11, "R4 first byte", v, 8'h11);
    wr_bit(1'b1);
    rd_bit(b);
    check(b === 1'b1, "R5 read after end", b, 1);
  endtask

  task automatic t_reset_abort();
    logic b;
    logic [7:0] v;
    rst_seq(b);
    check(b === 1'b1, "R2 read after reset", b, 1);
    send_addr(16'h003E);
    for (int i = 0; i < 3; i++) rd_bit(b);
    rst_seq(b);
    check(b === 1'b1, "R2 reset aborts read", b, 1);
    send_addr(16'h003F);
    rd_byte(v);
    check(v === 8'h22, "R2 R3 reload after reset", v, 8'h22);
    wr_bit(1'b1);
  endtask

  task automatic t_illegal();
    logic b;
    rd_bit(b); wr_bit(1'b0); wr_bit(1'b0);
    send_addr(16'h003F);
    rd_bit(b);
    check(b === 1'b1, "R10 rd-wr-wr idles", b, 1);
    rst_seq(b);
    send_addr(16'h003F);
    for (int i = 0; i < 3; i++) rd_bit(b);
    wr_bit(1'b1);
    rd_bit(b);
    check(b === 1'b1, "R10 wr1 mid byte", b, 1);
    rst_seq(b);
    for (int i = 0; i < 8; i++) wr_bit(1'b0);
    rd_bit(b); wr_bit(1'b1);
    for (int i = 0; i < 8; i++) wr_bit(1'b0);
    rd_bit(b);
    check(b === 1'b1, "R10 rd-wr1 in address", b, 1);
  endtask

  task automatic t_partial_byte();
    logic b;
    rst_seq(b);
    send_addr(16'h0020);
    for (int i = 0; i < 12; i++) wr_bit(1'b0);
    start_seq(b);
    rd_bit(b);
    check(b === 1'b1, "R7 partial no busy", b, 1);
    verify(8'h20, 1, "R7 partial no change");
  endtask

  task automatic t_wp_block();
    logic b;
    wp_n = 1'b0;
    wbuf[0] = 8'h00;
    load_page(8'h20, 1, 1'b0, b);
    rd_bit(b);
    check(b === 1'b1, "R9 protected no busy", b, 1);
    wp_n = 1'b1;
    verify(8'h20, 1, "R9 protected no change");
  endtask

  task automatic t_wp_during_busy();
    logic b;
    wbuf[0] = 8'h4B;
    load_page(8'h20, 1, 1'b1, b);
    wp_n = 1'b0;
    rd_bit(b);
    check(b === 1'b0, "R9 busy continues", b, 0);
    wait_done();
    wp_n = 1'b1;
    verify(8'h20, 1, "R9 write completes");
  endtask

  task automatic t_reset_in_busy();
    logic b, d;
    wbuf[0] = 8'h77;
    load_page(8'h21, 1, 1'b1, b);
    rd_bit(d); wr_bit(1'b0); rd_bit(b);
    check(d === 1'b0 && b === 1'b0, "R8 reset in busy", {d, b}, 0);
    wait_done();
    rd_bit(b);
    check(b === 1'b1, "R8 status after busy", b, 1);
    verify(8'h21, 1, "R8 busy write kept");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1; wp_n = 1'b1; dq_in = 1'b0;
    rst_n = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (5) @(posedge clk);
    t_reset_state();
    t_full_page();
    t_partial_update();
    t_page_wrap();
    t_rollover();
    t_end_read();
    t_reset_abort();
    t_illegal();
    t_partial_byte();
    t_wp_block();
    t_wp_during_busy();
    t_reset_in_busy();
    finish_run();
  end
endmodule